// File: doc/BRIEF.md
# SPI Receive Status and Fault Controller

This block holds the receive and error status of a byte-oriented SPI peripheral that sits on a simple CPU register bus. The serial shift engine is outside the block. It reports each finished byte as a one-cycle strobe that carries the byte. From that strobe the block keeps a receive-full flag and an overrun flag. It also captures the byte into a receive data register, but only when no unread byte is waiting. A slave-select input passes through a two-flop synchronizer. A falling edge on that synchronized input, seen while the peripheral is a master and fault detection is on, is a mode fault. The fault disables the peripheral, marks the transmitter empty, sends a one-cycle clear pulse to the transfer state counter, and gives the pins back to the general-purpose port.

No flag clears just because the CPU touches one register. Each flag runs its own two-state clear machine (`CLR_IDLE`, `CLR_ARMED`). Reading the status register while the flag is set takes the machine from `CLR_IDLE` to `CLR_ARMED`. The second access takes `CLR_ARMED` back to `CLR_IDLE` and clears the flag. For receive-full and overrun that access is a data read. For mode fault it is a control write. If the flag is set again while the machine is in `CLR_ARMED`, the machine returns to `CLR_IDLE` and the flag stays set. All three flags drive one interrupt output.

Control bit layout for `ctrl_wdata` and `ctrl_q`: bit 0 peripheral enable, bit 1 master select, bit 2 receive interrupt enable, bit 3 error interrupt enable, bit 4 mode-fault detect enable.

Top module: `spi_rx_status`

## Requirements
- R1: A receive strobe while `rx_full` is 0 loads `rx_byte` into `rx_data` and sets `rx_full` at the same clock edge.
- R2: A receive strobe while `rx_full` is 1 sets `rx_ovr` and leaves `rx_data` unchanged, so the new byte is dropped.
- R3: `rx_full` clears at the edge of a data read made in a cycle after a status read that saw `rx_full` at 1. A data read that has no such status read before it leaves `rx_full` set.
- R4: `rx_ovr` clears the same way, through a status read that sees it set and then a later data read. After that read `rx_data` still holds the older byte.
- R5: `mode_fault` sets on the third clock edge after `ss_n` falls, and only if master select (bit 1) and fault detect enable (bit 4) are both 1. With bit 4 at 0 a falling `ss_n` has no effect.
- R6: Writing 0 to fault detect enable leaves a `mode_fault` that is already set unchanged.
- R7: `mode_fault` clears at the edge of a control write made in a cycle after a status read that saw it at 1.
- R8: If a flag is set again after its arming status read and before the second access, that access does not clear it.
- R9: `irq` equals (`rx_full` AND bit 2) OR ((`rx_ovr` OR `mode_fault`) AND bit 3).
- R10: At the edge where a mode fault is recorded, enable (bit 0) goes to 0, `tx_empty` goes to 1, `pins_owned` goes to 0, and `cnt_clr` is 1 for exactly that one cycle. This takes priority over a control write in the same cycle.
- R11: A synchronous active-high reset clears every flag and every control bit and sets `tx_empty`. `tx_load` clears `tx_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle strobe from the shift engine: a byte has finished |
| rx_byte | input | 8 | Byte that goes with `rx_done` |
| ss_n | input | 1 | Asynchronous slave-select input, active low |
| rd_status | input | 1 | CPU reads the status register this cycle |
| rd_data | input | 1 | CPU reads the receive data register this cycle |
| wr_ctrl | input | 1 | CPU writes the control register this cycle |
| ctrl_wdata | input | 5 | Value written to the control bits |
| tx_load | input | 1 | CPU loads a transmit byte this cycle |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| mode_fault | output | 1 | Mode-fault flag |
| tx_empty | output | 1 | Transmit-empty flag |
| ctrl_q | output | 5 | Current control bits |
| pins_owned | output | 1 | Peripheral drives the shared pins |
| cnt_clr | output | 1 | One-cycle clear for the transfer state counter |
| irq | output | 1 | Combined receive/error interrupt request |

## Verification
The first receive pattern is a byte read out cleanly. The second is a stream where a third byte arrives before the second has been read, which separates keeping the old byte from taking the new one. It also shows that overrun stays set after the data read that clears receive-full. A data read with no status read before it shows whether clearing really depends on the arming step. A byte that arrives between the status read and the data read shows whether a repeated set cancels the clear. Slave-select falls with fault detection on, then off, then on again with a second fault inside the clear window. Together these separate the enable gate, the kept flag, and the cancelled clear. The interrupt enables are changed between phases so that each term of the interrupt equation shows up in the outputs compared every cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 5;
    localparam int NFLAG  = 3;

    // control bit positions
    localparam int C_EN    = 0;
    localparam int C_MSTR  = 1;
    localparam int C_RXIE  = 2;
    localparam int C_ERRIE = 3;
    localparam int C_MFEN  = 4;

    // flag indices
    localparam int F_FULL = 0;
    localparam int F_OVR  = 1;
    localparam int F_MF   = 2;

    typedef enum logic {
        CLR_IDLE  = 1'b0,
        CLR_ARMED = 1'b1
    } clr_state_t;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync (
    input  logic clk,
    input  logic rst,
    input  logic ss_n_in,
    output logic ss_fall
);
    logic ff1_q, ff2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff1_q  <= 1'b1;
            ff2_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            ff1_q  <= ss_n_in;
            ff2_q  <= ff1_q;
            prev_q <= ff2_q;
        end
    end

    assign ss_fall = prev_q & ~ff2_q;
endmodule

// File: rtl/spi_flag_clr.sv
module spi_flag_clr
    import spi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic chk_rd,
    input  logic fin_acc,
    output logic flag_q
);
    clr_state_t state_q, state_d;
    logic       clr_now;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CLR_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clr_now = 1'b0;
        unique case (state_q)
            CLR_IDLE: begin
                if (chk_rd && flag_q && !set_evt) state_d = CLR_ARMED;
            end
            CLR_ARMED: begin
                if (set_evt) begin
                    state_d = CLR_IDLE;
                end else if (fin_acc) begin
                    state_d = CLR_IDLE;
                    clr_now = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_now) flag_q <= 1'b0;
    end

    // R3 / R4 / R7: a flag only drops when its machine was armed
    p_clear_after_arm_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(state_q == CLR_ARMED));

    // R8: a new set always wins over a pending clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag_q);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ss_n,
    input  logic              rd_status,
    input  logic              rd_data,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              mode_fault,
    output logic              tx_empty,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              pins_owned,
    output logic              cnt_clr,
    output logic              irq
);
    logic             ss_fall;
    logic             mf_evt;
    logic [NFLAG-1:0] fl_set, fl_fin, fl_q;

    spi_ss_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .ss_n_in (ss_n),
        .ss_fall (ss_fall)
    );

    assign mf_evt         = ss_fall & ctrl_q[C_MSTR] & ctrl_q[C_MFEN];
    assign fl_set[F_FULL] = rx_done & ~fl_q[F_FULL];
    assign fl_set[F_OVR]  = rx_done &  fl_q[F_FULL];
    assign fl_set[F_MF]   = mf_evt;
    assign fl_fin[F_FULL] = rd_data;
    assign fl_fin[F_OVR]  = rd_data;
    assign fl_fin[F_MF]   = wr_ctrl;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        spi_flag_clr u_fl (
            .clk     (clk),
            .rst     (rst),
            .set_evt (fl_set[i]),
            .chk_rd  (rd_status),
            .fin_acc (fl_fin[i]),
            .flag_q  (fl_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            ctrl_q   <= '0;
            tx_empty <= 1'b1;
            cnt_clr  <= 1'b0;
        end else begin
            if (fl_set[F_FULL]) rx_data <= rx_byte;
            if (wr_ctrl)        ctrl_q  <= ctrl_wdata;
            if (mf_evt)         ctrl_q[C_EN] <= 1'b0;
            if (mf_evt)         tx_empty <= 1'b1;
            else if (tx_load)   tx_empty <= 1'b0;
            cnt_clr <= mf_evt;
        end
    end

    assign rx_full    = fl_q[F_FULL];
    assign rx_ovr     = fl_q[F_OVR];
    assign mode_fault = fl_q[F_MF];
    assign pins_owned = ctrl_q[C_EN];
    assign irq        = (rx_full & ctrl_q[C_RXIE])
                      | ((rx_ovr | mode_fault) & ctrl_q[C_ERRIE]);

    // R2: an overrunning byte never reaches the data register
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full) |=> rx_data == $past(rx_data));

    // R5: a fault is recorded only with detection enabled
    p_fault_gate_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault) |-> $past(ctrl_q[C_MFEN] && ctrl_q[C_MSTR]));

    // R10: the fault shuts the peripheral down at the same edge
    p_shutdown_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |-> (mode_fault && tx_empty && !pins_owned));
endmodule

// File: tb/sim_spi_rx_status.sv
module sim_spi_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       ss_n = 1'b1;
    logic       rd_status = 1'b0, rd_data = 1'b0, wr_ctrl = 1'b0, tx_load = 1'b0;
    logic [4:0] ctrl_wdata = '0;

    logic [7:0] rx_data;
    logic       rx_full, rx_ovr, mode_fault, tx_empty, pins_owned, cnt_clr, irq;
    logic [4:0] ctrl_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit live  = 1'b0;

    spi_rx_status u0 (
        .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte), .ss_n(ss_n),
        .rd_status(rd_status), .rd_data(rd_data), .wr_ctrl(wr_ctrl),
        .ctrl_wdata(ctrl_wdata), .tx_load(tx_load), .rx_data(rx_data),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .mode_fault(mode_fault),
        .tx_empty(tx_empty), .ctrl_q(ctrl_q), .pins_owned(pins_owned),
        .cnt_clr(cnt_clr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit [7:0] m_data;
    bit [4:0] m_ctrl;
    bit m_full, m_ovr, m_mf, m_tx, m_clr;
    bit a_full, a_ovr, a_mf;
    bit s1, s2, s3;

    always @(posedge clk) begin
        bit fall, mfev, new_byte, lost;
        if (rst) begin
            m_data = 0; m_ctrl = 0; m_full = 0; m_ovr = 0; m_mf = 0;
            m_tx = 1; m_clr = 0; a_full = 0; a_ovr = 0; a_mf = 0;
            s1 = 1; s2 = 1; s3 = 1;
        end else begin
            fall     = s3 && !s2;
            mfev     = fall && m_ctrl[1] && m_ctrl[4];
            new_byte = rx_done && !m_full;
            lost     = rx_done && m_full;
            // receive-full
            if (new_byte) begin m_full = 1; m_data = rx_byte; a_full = 0; end
            else if (a_full && rd_data) begin m_full = 0; a_full = 0; end
            else if (!a_full && rd_status && m_full) a_full = 1;
            // overrun
            if (lost) begin m_ovr = 1; a_ovr = 0; end
            else if (a_ovr && rd_data) begin m_ovr = 0; a_ovr = 0; end
            else if (!a_ovr && rd_status && m_ovr) a_ovr = 1;
            // mode fault
            if (mfev) begin m_mf = 1; a_mf = 0; end
            else if (a_mf && wr_ctrl) begin m_mf = 0; a_mf = 0; end
            else if (!a_mf && rd_status && m_mf) a_mf = 1;
            if (wr_ctrl) m_ctrl = ctrl_wdata;
            if (mfev) begin m_ctrl[0] = 0; m_tx = 1; end
            else if (tx_load) m_tx = 0;
            m_clr = mfev;
            s3 = s2; s2 = s1; s1 = ss_n;
        end
        live = 1'b1;
    end

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the reference on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (live && !done) begin
            chk(rx_full,    m_full, "R1 R3 rx_full");
            chk(rx_ovr,     m_ovr,  "R2 R4 rx_ovr");
            chk(rx_data,    m_data, "R1 R2 rx_data");
            chk(mode_fault, m_mf,   "R5 R7 mode_fault");
            chk(irq, (m_full && m_ctrl[2]) || ((m_ovr || m_mf) && m_ctrl[3]), "R9 irq");
            chk(ctrl_q,     m_ctrl, "R10 ctrl_q");
            chk(tx_empty,   m_tx,   "R10 R11 tx_empty");
            chk(pins_owned, m_ctrl[0], "R10 pins_owned");
            chk(cnt_clr,    m_clr,  "R10 cnt_clr");
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic rx(input logic [7:0] b);
        rx_done = 1; rx_byte = b; tick(); rx_done = 0;
    endtask
    task automatic st_rd();
        rd_status = 1; tick(); rd_status = 0;
    endtask
    task automatic dt_rd();
        rd_data = 1; tick(); rd_data = 0;
    endtask
    task automatic cw(input logic [4:0] v);
        wr_ctrl = 1; ctrl_wdata = v; tick(); wr_ctrl = 0;
    endtask

    initial begin : main
        tick(3);
        rst = 0;
        tick();
        // R11 reset state
        chk(rx_full | rx_ovr | mode_fault | cnt_clr, 0, "R11 flags after reset");
        chk(tx_empty, 1, "R11 tx_empty after reset");
        chk(ctrl_q, 0, "R11 ctrl after reset");
        tx_load = 1; tick(); tx_load = 0;
        chk(tx_empty, 0, "R11 tx_load clears");

        cw(5'b01111);                 // en, master, rx_ie, err_ie
        rx(8'hA5);
        chk(rx_full, 1, "R1 set"); chk(rx_data, 8'hA5, "R1 data");
        chk(irq, 1, "R9 rx irq");
        st_rd(); dt_rd();
        chk(rx_full, 0, "R3 clear");

        // overrun sequence
        rx(8'h3C); st_rd(); rx(8'h77);
        chk(rx_ovr, 1, "R2 ovr set"); chk(rx_data, 8'h3C, "R2 byte kept");
        dt_rd();
        chk(rx_full, 0, "R3 full clears"); chk(rx_ovr, 1, "R4 ovr stays");
        st_rd(); dt_rd();
        chk(rx_ovr, 0, "R4 ovr clear"); chk(rx_data, 8'h3C, "R4 old byte");
        rx(8'h99); chk(rx_data, 8'h99, "R1 next byte");
        st_rd(); dt_rd();

        // data read without arming
        rx(8'h11); dt_rd();
        chk(rx_full, 1, "R3 unarmed read");
        st_rd(); dt_rd();

        // re-set cancels pending overrun clear, no interrupts enabled
        cw(5'b00011);
        rx(8'h22); st_rd(); rx(8'h33);
        chk(irq, 0, "R9 masked");
        st_rd(); rx(8'h44); dt_rd();
        chk(rx_full, 0, "R8 full clears"); chk(rx_ovr, 1, "R8 ovr kept");
        st_rd(); dt_rd();
        chk(rx_ovr, 0, "R4 ovr clear later");

        // mode fault
        cw(5'b11011);                 // en, master, err_ie, fault_en
        ss_n = 0; tick(2);
        chk(mode_fault, 0, "R5 not yet");
        tick();
        chk(mode_fault, 1, "R5 fault"); chk(cnt_clr, 1, "R10 pulse");
        chk(ctrl_q[0], 0, "R10 disabled"); chk(tx_empty, 1, "R10 tx_empty");
        tick();
        chk(cnt_clr, 0, "R10 single pulse");
        ss_n = 1; tick(3);
        cw(5'b01010);                 // fault_en off
        chk(mode_fault, 1, "R6 kept");
        st_rd(); cw(5'b01010);
        chk(mode_fault, 0, "R7 cleared");
        ss_n = 0; tick(4);
        chk(mode_fault, 0, "R5 gated off");
        ss_n = 1; tick(3);
        cw(5'b11011);
        ss_n = 0; tick(4);
        chk(mode_fault, 1, "R5 second fault");
        st_rd(); ss_n = 1; tick(3);
        cw(5'b11011);                 // clears: armed, no re-set
        chk(mode_fault, 0, "R7 clear again");
        ss_n = 0; tick(4);
        st_rd(); ss_n = 1; tick(3); ss_n = 0; tick(4);
        cw(5'b11011);
        chk(mode_fault, 1, "R8 fault re-set cancels");
        ss_n = 1; tick(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : wd
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R11 act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule